// File: doc/BRIEF.md
# Accumulator Transfer Instruction Executor

This block executes the data-transfer instructions of a small 8-bit controller core. The core has a 16-bit accumulator, split into a high byte and a low byte, and a 16-bit temporary register. The block fetches its own opcodes and operands through a byte-wide memory port. It moves bytes and words between the accumulator and immediate operands, page-0 direct addresses, extended addresses, the location held in the pointer register, and a file of eight byte registers. It copies and exchanges the accumulator with the pointer, index and stack registers and with the temporary register. It also sets or clears single bits in page-0 bytes.

The memory port is combinational on reads: the byte at `memAddr` must be present on `memRdata` in the same cycle. Writes take effect at the next rising edge. Every instruction has a fixed cycle count, and `done` is high in its last cycle. Register and flag updates of an instruction take effect at the edge that closes that cycle. Any load of a value into the accumulator first saves the old accumulator value into the temporary register.

Top module: `xfer_exec`

## Requirements
- R1: While `rstN` is low, the accumulator, temporary, pointer, index and stack registers, the program counter and the flag vector are all zero, and the next fetch is from address 0.
- R2: A byte load into the accumulator (04 imm, 05 dir, 60 ext, 07 via pointer, 08+i from register i) writes the byte to the low byte only and leaves the high byte unchanged. At the same edge the old low byte moves into the low byte of the temporary register, whose high byte is left unchanged.
- R3: A word load (E4 imm, C5 dir, C4 ext, C7 via pointer) copies the old 16-bit accumulator into the temporary register and loads the new word. The byte at address n, or the first immediate byte, becomes the high byte, and the byte at n+1 becomes the low byte.
- R4: A word store (D5 dir, D4 ext, D7 via pointer) writes the high byte to address n and then the low byte to n+1 in the next cycle. A byte store (45 dir, 61 ext, 47 via pointer) writes the low byte.
- R5: The flag vector is {N,Z,V,C} in bits 3..0. A load into the accumulator sets N from bit 7 (byte load) or bit 15 (word load) and sets Z when the loaded byte or word is zero. V and C are unchanged. Opcode 71 loads all four flags from accumulator bits 3..0. Opcode 70 loads the accumulator with the flags, zero-extended. Every other instruction leaves the flags unchanged.
- R6: E3/E2/E1 copy the accumulator into the pointer, index or stack register. F3/F2/F1 copy that register into the accumulator. E7/E6/E5 load it with a 16-bit immediate, high byte first. None of these touch the temporary register.
- R7: 10 swaps the two accumulator bytes. 42 swaps only the accumulator low byte with the temporary register's low byte. 43/F7/F6/F5 swap the full accumulator with the temporary, pointer, index or stack register.
- R8: 48+i stores the accumulator low byte into byte register i (i = opcode bits 2..0). 08+i loads it back as a byte load.
- R9: A8+b sets and A0+b clears bit b (opcode bits 2..0) of a page-0 byte by read then write. The other seven bits are unchanged.
- R10: Cycle counts are: 2 for 04, 10, 42, 70, 71, E1-E3 and F1-F3; 3 for 05, 07, 08-0F, 45, 47, 48-4F, 43, E4, E5-E7 and F5-F7; 4 for 60, 61, C5, C7, D5, D7 and A0-AF; 5 for C4 and D4. `done` is high only in the last cycle, and the next cycle fetches the next opcode.
- R11: Any other opcode takes one cycle, raises `illegal` with `done`, advances the program counter by one, writes no memory and changes no register or flag.
- R12: An extended address follows the opcode high byte first. A direct address is the single byte after the opcode, placed in page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 16 | Memory address of this cycle |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data, valid in the same cycle |
| done | output | 1 | Last cycle of an instruction |
| illegal | output | 1 | Unsupported opcode seen this cycle |
| accOut | output | 16 | Accumulator |
| tmpOut | output | 16 | Temporary register |
| epOut | output | 16 | Pointer register |
| ixOut | output | 16 | Index register |
| spOut | output | 16 | Stack register |
| pcOut | output | 16 | Program counter |
| flagsOut | output | 4 | {N,Z,V,C} |

## Verification
For immediate loads (04, E4, E7), the capture of the final operand byte and the commit of the register write fall in the same cycle. For every load, saving the old accumulator into the temporary register and writing the new value also happen at one edge. The program chains immediate byte and word loads back to back with alternating zero, negative and mixed values. This exposes any stale-buffer read or any ordering error between the save and the load. A behavioural interpreter in the bench predicts the accumulator, temporary register and flags after each instruction, and the bench compares them at the first cycle of the following instruction.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int ADDR_W   = 16;
  localparam int RI_NUM   = 8;
  localparam int RI_IDX_W = $clog2(RI_NUM);
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int STEP_W   = 3;
  localparam int FLAG_W   = 4;
  localparam int FL_N     = 3;
  localparam int FL_Z     = 2;

  typedef enum logic [2:0] {AS_PC, AS_EA, AS_EA1, AS_EP, AS_EP1} addrSel_e;
  typedef enum logic [1:0] {WD_AH, WD_AL, WD_BIT} wdSel_e;
  typedef enum logic [2:0] {MD_NONE, MD_IMM, MD_DIR, MD_EXT, MD_EPI, MD_RI, MD_BIT} mode_e;
  typedef enum logic [4:0] {
    CM_NONE, CM_LDA8, CM_LDA16, CM_STRI,
    CM_EP_A, CM_A_EP, CM_IX_A, CM_A_IX, CM_SP_A, CM_A_SP,
    CM_EP_IMM, CM_IX_IMM, CM_SP_IMM, CM_A_PS, CM_PS_A,
    CM_SWAP, CM_XCH8, CM_XCHW_T, CM_XCHW_EP, CM_XCHW_IX, CM_XCHW_SP
  } commit_e;

  typedef struct packed {
    logic                 legal;
    mode_e                mode;
    logic                 isWr;
    logic                 wide;
    logic [STEP_W-1:0]    lastStep;
    commit_e              commit;
  } dec_t;

  typedef struct packed {
    logic                 rd;
    logic                 wr;
    addrSel_e             addrSel;
    wdSel_e               wdSel;
    logic                 pcInc;
    logic                 eaDir;
    logic                 eaHi;
    logic                 eaLo;
    logic                 shIn;
    logic                 riToBuf;
    commit_e              commit;
    logic [RI_IDX_W-1:0]  riIdx;
    logic [BIT_IDX_W-1:0] bitIdx;
    logic                 bitSet;
  } strb_t;

  function automatic dec_t mk(mode_e m, logic w, logic wd, int last, commit_e c);
    dec_t d;
    d.legal    = 1'b1;
    d.mode     = m;
    d.isWr     = w;
    d.wide     = wd;
    d.lastStep = STEP_W'(last);
    d.commit   = c;
    return d;
  endfunction

  function automatic dec_t decode(input logic [BYTE_W-1:0] op);
    dec_t d;
    d = mk(MD_NONE, 1'b0, 1'b0, 0, CM_NONE);
    d.legal = 1'b0;
    casez (op)
      8'h04:        d = mk(MD_IMM, 1'b0, 1'b0, 1, CM_LDA8);
      8'h05:        d = mk(MD_DIR, 1'b0, 1'b0, 2, CM_LDA8);
      8'h60:        d = mk(MD_EXT, 1'b0, 1'b0, 3, CM_LDA8);
      8'h07:        d = mk(MD_EPI, 1'b0, 1'b0, 2, CM_LDA8);
      8'b0000_1???: d = mk(MD_RI,  1'b0, 1'b0, 2, CM_LDA8);
      8'h45:        d = mk(MD_DIR, 1'b1, 1'b0, 2, CM_NONE);
      8'h61:        d = mk(MD_EXT, 1'b1, 1'b0, 3, CM_NONE);
      8'h47:        d = mk(MD_EPI, 1'b1, 1'b0, 2, CM_NONE);
      8'b0100_1???: d = mk(MD_NONE, 1'b0, 1'b0, 2, CM_STRI);
      8'hE4:        d = mk(MD_IMM, 1'b0, 1'b1, 2, CM_LDA16);
      8'hC5:        d = mk(MD_DIR, 1'b0, 1'b1, 3, CM_LDA16);
      8'hC4:        d = mk(MD_EXT, 1'b0, 1'b1, 4, CM_LDA16);
      8'hC7:        d = mk(MD_EPI, 1'b0, 1'b1, 3, CM_LDA16);
      8'hD5:        d = mk(MD_DIR, 1'b1, 1'b1, 3, CM_NONE);
      8'hD4:        d = mk(MD_EXT, 1'b1, 1'b1, 4, CM_NONE);
      8'hD7:        d = mk(MD_EPI, 1'b1, 1'b1, 3, CM_NONE);
      8'hE3:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_EP_A);
      8'hF3:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_A_EP);
      8'hE2:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_IX_A);
      8'hF2:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_A_IX);
      8'hE1:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_SP_A);
      8'hF1:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_A_SP);
      8'hE7:        d = mk(MD_IMM, 1'b0, 1'b1, 2, CM_EP_IMM);
      8'hE6:        d = mk(MD_IMM, 1'b0, 1'b1, 2, CM_IX_IMM);
      8'hE5:        d = mk(MD_IMM, 1'b0, 1'b1, 2, CM_SP_IMM);
      8'h70:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_A_PS);
      8'h71:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_PS_A);
      8'h10:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_SWAP);
      8'h42:        d = mk(MD_NONE, 1'b0, 1'b0, 1, CM_XCH8);
      8'h43:        d = mk(MD_NONE, 1'b0, 1'b0, 2, CM_XCHW_T);
      8'hF7:        d = mk(MD_NONE, 1'b0, 1'b0, 2, CM_XCHW_EP);
      8'hF6:        d = mk(MD_NONE, 1'b0, 1'b0, 2, CM_XCHW_IX);
      8'hF5:        d = mk(MD_NONE, 1'b0, 1'b0, 2, CM_XCHW_SP);
      8'b1010_????: d = mk(MD_BIT, 1'b0, 1'b0, 3, CM_NONE);
      default:      ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] memRdata,
  output strb_t             strb,
  output logic              done,
  output logic              illegal
);
  logic [STEP_W-1:0] step;
  logic [BYTE_W-1:0] opReg;
  logic [BYTE_W-1:0] curOp;
  dec_t              dec;

  assign curOp   = (step == '0) ? memRdata : opReg;
  assign dec     = decode(curOp);
  assign illegal = (step == '0) && !dec.legal;
  assign done    = (step == '0) ? !dec.legal : (step == dec.lastStep);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step  <= '0;
      opReg <= '0;
    end else if (step == '0) begin
      opReg <= memRdata;
      if (dec.legal) step <= STEP_W'(1);
    end else if (step == dec.lastStep) begin
      step <= '0;
    end else begin
      step <= step + STEP_W'(1);
    end
  end

  always_comb begin
    int stepI, addrBytes, dataN, dIdx;
    strb         = '0;
    strb.addrSel = AS_PC;
    strb.wdSel   = WD_AL;
    strb.commit  = CM_NONE;
    strb.riIdx   = curOp[RI_IDX_W-1:0];
    strb.bitIdx  = curOp[BIT_IDX_W-1:0];
    strb.bitSet  = curOp[BIT_IDX_W];
    stepI     = int'(step);
    addrBytes = (dec.mode == MD_DIR || dec.mode == MD_BIT) ? 1 : (dec.mode == MD_EXT) ? 2 : 0;
    dataN     = dec.wide ? 2 : 1;
    dIdx      = stepI - addrBytes - 1;
    if (stepI == 0) begin
      strb.rd    = 1'b1;
      strb.pcInc = 1'b1;
    end else if (stepI <= addrBytes) begin
      strb.rd    = 1'b1;
      strb.pcInc = 1'b1;
      if (addrBytes == 1)  strb.eaDir = 1'b1;
      else if (stepI == 1) strb.eaHi  = 1'b1;
      else                 strb.eaLo  = 1'b1;
    end else if (dec.mode == MD_BIT) begin
      strb.addrSel = AS_EA;
      if (stepI == 2) begin
        strb.rd   = 1'b1;
        strb.shIn = 1'b1;
      end else begin
        strb.wr    = 1'b1;
        strb.wdSel = WD_BIT;
      end
    end else if (dIdx < dataN) begin
      unique case (dec.mode)
        MD_IMM: begin
          strb.rd    = 1'b1;
          strb.pcInc = 1'b1;
          strb.shIn  = 1'b1;
        end
        MD_DIR, MD_EXT, MD_EPI: begin
          if (dec.mode == MD_EPI) strb.addrSel = (dIdx == 0) ? AS_EP : AS_EP1;
          else                    strb.addrSel = (dIdx == 0) ? AS_EA : AS_EA1;
          if (dec.isWr) begin
            strb.wr    = 1'b1;
            strb.wdSel = (dec.wide && dIdx == 0) ? WD_AH : WD_AL;
          end else begin
            strb.rd   = 1'b1;
            strb.shIn = 1'b1;
          end
        end
        MD_RI:   strb.riToBuf = 1'b1;
        default: ;
      endcase
    end
    if (stepI != 0 && step == dec.lastStep) strb.commit = dec.commit;
  end
endmodule

// File: rtl/xfer_dp.sv
module xfer_dp
  import xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [BYTE_W-1:0] memWdata,
  output logic [WORD_W-1:0] accOut,
  output logic [WORD_W-1:0] tmpOut,
  output logic [WORD_W-1:0] epOut,
  output logic [WORD_W-1:0] ixOut,
  output logic [WORD_W-1:0] spOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic [FLAG_W-1:0] flagsOut
);
  logic [WORD_W-1:0] a, t, ep, ix, sp, dBuf, newBuf;
  logic [ADDR_W-1:0] pc, ea;
  logic [FLAG_W-1:0] flags;
  logic [BYTE_W-1:0] ri [RI_NUM];
  logic [BYTE_W-1:0] bitMask;

  assign bitMask = BYTE_W'(1) << strb.bitIdx;

  always_comb begin
    if (strb.shIn)         newBuf = {dBuf[BYTE_W-1:0], memRdata};
    else if (strb.riToBuf) newBuf = {dBuf[BYTE_W-1:0], ri[strb.riIdx]};
    else                   newBuf = dBuf;
  end

  always_comb begin
    unique case (strb.addrSel)
      AS_EA:   memAddr = ea;
      AS_EA1:  memAddr = ea + ADDR_W'(1);
      AS_EP:   memAddr = ep;
      AS_EP1:  memAddr = ep + ADDR_W'(1);
      default: memAddr = pc;
    endcase
    unique case (strb.wdSel)
      WD_AH:   memWdata = a[WORD_W-1:BYTE_W];
      WD_BIT:  memWdata = strb.bitSet ? (dBuf[BYTE_W-1:0] | bitMask) : (dBuf[BYTE_W-1:0] & ~bitMask);
      default: memWdata = a[BYTE_W-1:0];
    endcase
  end

  assign memRd    = strb.rd;
  assign memWr    = strb.wr;
  assign accOut   = a;
  assign tmpOut   = t;
  assign epOut    = ep;
  assign ixOut    = ix;
  assign spOut    = sp;
  assign pcOut    = pc;
  assign flagsOut = flags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      a <= '0; t <= '0; ep <= '0; ix <= '0; sp <= '0;
      pc <= '0; ea <= '0; dBuf <= '0; flags <= '0;
      for (int i = 0; i < RI_NUM; i++) ri[i] <= '0;
    end else begin
      if (strb.pcInc) pc <= pc + ADDR_W'(1);
      if (strb.eaDir) ea <= {{(ADDR_W-BYTE_W){1'b0}}, memRdata};
      if (strb.eaHi)  ea[ADDR_W-1:BYTE_W] <= memRdata;
      if (strb.eaLo)  ea[BYTE_W-1:0] <= memRdata;
      dBuf <= newBuf;
      unique case (strb.commit)
        CM_LDA8: begin
          a[BYTE_W-1:0] <= newBuf[BYTE_W-1:0];
          t[BYTE_W-1:0] <= a[BYTE_W-1:0];
          flags[FL_N]   <= newBuf[BYTE_W-1];
          flags[FL_Z]   <= (newBuf[BYTE_W-1:0] == '0);
        end
        CM_LDA16: begin
          a           <= newBuf;
          t           <= a;
          flags[FL_N] <= newBuf[WORD_W-1];
          flags[FL_Z] <= (newBuf == '0);
        end
        CM_STRI:    ri[strb.riIdx] <= a[BYTE_W-1:0];
        CM_EP_A:    ep <= a;
        CM_A_EP:    a  <= ep;
        CM_IX_A:    ix <= a;
        CM_A_IX:    a  <= ix;
        CM_SP_A:    sp <= a;
        CM_A_SP:    a  <= sp;
        CM_EP_IMM:  ep <= newBuf;
        CM_IX_IMM:  ix <= newBuf;
        CM_SP_IMM:  sp <= newBuf;
        CM_A_PS:    a  <= {{(WORD_W-FLAG_W){1'b0}}, flags};
        CM_PS_A:    flags <= a[FLAG_W-1:0];
        CM_SWAP:    a  <= {a[BYTE_W-1:0], a[WORD_W-1:BYTE_W]};
        CM_XCH8: begin
          a[BYTE_W-1:0] <= t[BYTE_W-1:0];
          t[BYTE_W-1:0] <= a[BYTE_W-1:0];
        end
        CM_XCHW_T:  begin a <= t;  t  <= a; end
        CM_XCHW_EP: begin a <= ep; ep <= a; end
        CM_XCHW_IX: begin a <= ix; ix <= a; end
        CM_XCHW_SP: begin a <= sp; sp <= a; end
        default: ;
      endcase
    end
  end

  // R2: byte load keeps the high byte and saves only the low byte
  p_byte_load_low_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit == CM_LDA8 |=> a[WORD_W-1:BYTE_W] == $past(a[WORD_W-1:BYTE_W])
      && t[BYTE_W-1:0] == $past(a[BYTE_W-1:0]) && t[WORD_W-1:BYTE_W] == $past(t[WORD_W-1:BYTE_W]));

  // R4: high byte written first, low byte at the next address one cycle later
  p_word_store_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWr && strb.wdSel == WD_AH |=> memWr && strb.wdSel == WD_AL
      && memAddr == $past(memAddr) + ADDR_W'(1));

  // R5: only loads into A and the flag-load opcode touch the flags
  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.commit inside {CM_LDA8, CM_LDA16, CM_PS_A}) |=> flags == $past(flags));

  // R9: a bit operation changes at most one bit of the byte it read
  p_bit_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWr && strb.wdSel == WD_BIT |-> $countones(memWdata ^ dBuf[BYTE_W-1:0]) <= 1);
endmodule

// File: rtl/xfer_exec.sv
module xfer_exec
  import xfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output logic [15:0] memAddr,
  output logic        memRd,
  output logic        memWr,
  output logic [7:0]  memWdata,
  input  logic [7:0]  memRdata,
  output logic        done,
  output logic        illegal,
  output logic [15:0] accOut,
  output logic [15:0] tmpOut,
  output logic [15:0] epOut,
  output logic [15:0] ixOut,
  output logic [15:0] spOut,
  output logic [15:0] pcOut,
  output logic [3:0]  flagsOut
);
  strb_t strb;

  xfer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .memRdata(memRdata),
    .strb(strb), .done(done), .illegal(illegal)
  );

  xfer_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .accOut(accOut), .tmpOut(tmpOut), .epOut(epOut), .ixOut(ixOut),
    .spOut(spOut), .pcOut(pcOut), .flagsOut(flagsOut)
  );

  // R11: an unsupported opcode writes nothing and only steps the program counter
  p_illegal_no_effect_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !memWr);
  p_illegal_state_kept_r11: assert property (@(posedge clk) disable iff (!rstN)
    illegal |=> accOut == $past(accOut) && tmpOut == $past(tmpOut)
      && flagsOut == $past(flagsOut) && pcOut == $past(pcOut) + 16'd1);

  // R10: the cycle after completion fetches the next opcode at the program counter
  p_fetch_after_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> memRd && !memWr && memAddr == pcOut);
endmodule

// File: tb/sim_xfer_exec.sv
`timescale 1ns/1ps
module sim_xfer_exec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr;
  logic        memRd, memWr, done, illegal;
  logic [7:0]  memWdata, memRdata;
  logic [15:0] accOut, tmpOut, epOut, ixOut, spOut, pcOut;
  logic [3:0]  flagsOut;

  logic [7:0]  mem [1024];
  logic [7:0]  refMem [1024];
  logic [15:0] rA, rT, rEp, rIx, rSp, rPc;
  logic [3:0]  rFl;
  logic [7:0]  rRi [8];
  int nChk = 0, nErr = 0, progEnd = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xfer_exec u0 (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWr(memWr),
    .memWdata(memWdata), .memRdata(memRdata), .done(done), .illegal(illegal),
    .accOut(accOut), .tmpOut(tmpOut), .epOut(epOut), .ixOut(ixOut),
    .spOut(spOut), .pcOut(pcOut), .flagsOut(flagsOut)
  );

  assign memRdata = mem[memAddr[9:0]];
  always @(posedge clk) if (memWr) mem[memAddr[9:0]] <= memWdata;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    mem[progEnd] = b;
    refMem[progEnd] = b;
    progEnd++;
  endtask

  function automatic logic [7:0] m(logic [15:0] ad);
    return refMem[ad[9:0]];
  endfunction

  task automatic ldb(logic [7:0] v);
    rT[7:0] = rA[7:0]; rA[7:0] = v; rFl[3] = v[7]; rFl[2] = (v == 8'h00);
  endtask

  task automatic ldw(logic [15:0] v);
    rT = rA; rA = v; rFl[3] = v[15]; rFl[2] = (v == 16'h0000);
  endtask

  task automatic model(output int n, output bit ill, output string tag);
    logic [7:0] op, d, v;
    logic [15:0] ad, tmp;
    op = m(rPc); d = m(rPc + 16'd1); ad = {m(rPc + 16'd1), m(rPc + 16'd2)};
    ill = 0; n = 2; tag = "R6";
    casez (op)
      8'h04: begin ldb(d); rPc += 2; n = 2; tag = "R2"; end
      8'h05: begin ldb(m({8'h00, d})); rPc += 2; n = 3; tag = "R12"; end
      8'h60: begin ldb(m(ad)); rPc += 3; n = 4; tag = "R12"; end
      8'h07: begin ldb(m(rEp)); rPc += 1; n = 3; tag = "R2"; end
      8'b0000_1???: begin ldb(rRi[op[2:0]]); rPc += 1; n = 3; tag = "R8"; end
      8'h45: begin refMem[d] = rA[7:0]; rPc += 2; n = 3; tag = "R4"; end
      8'h61: begin refMem[ad[9:0]] = rA[7:0]; rPc += 3; n = 4; tag = "R4"; end
      8'h47: begin refMem[rEp[9:0]] = rA[7:0]; rPc += 1; n = 3; tag = "R4"; end
      8'b0100_1???: begin rRi[op[2:0]] = rA[7:0]; rPc += 1; n = 3; tag = "R8"; end
      8'hE4: begin ldw(ad); rPc += 3; n = 3; tag = "R3"; end
      8'hC5: begin ldw({m({8'h00, d}), m({8'h00, d} + 16'd1)}); rPc += 2; n = 4; tag = "R3"; end
      8'hC4: begin ldw({m(ad), m(ad + 16'd1)}); rPc += 3; n = 5; tag = "R3"; end
      8'hC7: begin ldw({m(rEp), m(rEp + 16'd1)}); rPc += 1; n = 4; tag = "R3"; end
      8'hD5: begin refMem[d] = rA[15:8]; refMem[d + 8'd1] = rA[7:0]; rPc += 2; n = 4; tag = "R4"; end
      8'hD4: begin refMem[ad[9:0]] = rA[15:8]; refMem[ad[9:0] + 10'd1] = rA[7:0]; rPc += 3; n = 5; tag = "R4"; end
      8'hD7: begin refMem[rEp[9:0]] = rA[15:8]; refMem[rEp[9:0] + 10'd1] = rA[7:0]; rPc += 1; n = 4; tag = "R4"; end
      8'hE3: begin rEp = rA; rPc += 1; end
      8'hF3: begin rA = rEp; rPc += 1; end
      8'hE2: begin rIx = rA; rPc += 1; end
      8'hF2: begin rA = rIx; rPc += 1; end
      8'hE1: begin rSp = rA; rPc += 1; end
      8'hF1: begin rA = rSp; rPc += 1; end
      8'hE7: begin rEp = ad; rPc += 3; n = 3; end
      8'hE6: begin rIx = ad; rPc += 3; n = 3; end
      8'hE5: begin rSp = ad; rPc += 3; n = 3; end
      8'h70: begin rA = {12'h000, rFl}; rPc += 1; tag = "R5"; end
      8'h71: begin rFl = rA[3:0]; rPc += 1; tag = "R5"; end
      8'h10: begin rA = {rA[7:0], rA[15:8]}; rPc += 1; tag = "R7"; end
      8'h42: begin v = rA[7:0]; rA[7:0] = rT[7:0]; rT[7:0] = v; rPc += 1; tag = "R7"; end
      8'h43: begin tmp = rA; rA = rT;  rT = tmp;  rPc += 1; n = 3; tag = "R7"; end
      8'hF7: begin tmp = rA; rA = rEp; rEp = tmp; rPc += 1; n = 3; tag = "R7"; end
      8'hF6: begin tmp = rA; rA = rIx; rIx = tmp; rPc += 1; n = 3; tag = "R7"; end
      8'hF5: begin tmp = rA; rA = rSp; rSp = tmp; rPc += 1; n = 3; tag = "R7"; end
      8'b1010_????: begin
        v = refMem[d]; v[op[2:0]] = op[3]; refMem[d] = v; rPc += 2; n = 4; tag = "R9";
      end
      default: begin ill = 1; rPc += 1; n = 1; tag = "R11"; end
    endcase
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nErr++; nChk++;
      $display("FAIL R10 watchdog: actual=%h expected=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

  initial begin
    int n; bit ill; string tag; int mism;
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'(i * 7 + 1); refMem[i] = 8'(i * 7 + 1); end
    mem[10'h0B0] = 8'h3C; refMem[10'h0B0] = 8'h3C;
    progEnd = 0;
    put(8'hE4); put(8'h12); put(8'h34);           // word imm
    put(8'h04); put(8'h00);                       // byte zero, Z
    put(8'h04); put(8'h85);                       // byte negative
    put(8'hE4); put(8'h00); put(8'h00);           // word zero
    put(8'hE4); put(8'h80); put(8'h01);           // word negative
    put(8'hE7); put(8'h03); put(8'h00);           // EP = 0300
    put(8'hE6); put(8'h01); put(8'h23);
    put(8'hE5); put(8'h02); put(8'hFF);
    put(8'hD5); put(8'h90); put(8'hC5); put(8'h90);
    put(8'hE4); put(8'h5E); put(8'hA7);
    put(8'hD4); put(8'h02); put(8'h00); put(8'hC4); put(8'h02); put(8'h00);
    put(8'hE4); put(8'hAB); put(8'hCD); put(8'hD7);
    put(8'h04); put(8'h5A); put(8'h47); put(8'hC7); put(8'h07);
    put(8'h60); put(8'h02); put(8'h01);
    put(8'h45); put(8'hA0); put(8'h04); put(8'h11); put(8'h05); put(8'hA0);
    put(8'h61); put(8'h02); put(8'h10); put(8'h60); put(8'h02); put(8'h10);
    for (int i = 0; i < 8; i++) begin put(8'h04); put(8'(i * 37 + 3)); put(8'(8'h48 + i)); end
    for (int i = 0; i < 8; i++) put(8'(8'h08 + 7 - i));
    put(8'h10); put(8'h42); put(8'h43); put(8'hF7); put(8'hF6); put(8'hF5);
    put(8'hE3); put(8'hF3); put(8'hE2); put(8'hF2); put(8'hE1); put(8'hF1);
    put(8'hE4); put(8'h00); put(8'h0A); put(8'h71); put(8'h70);
    put(8'hE4); put(8'hFF); put(8'h05); put(8'h71); put(8'h04); put(8'h01); put(8'h70);
    put(8'hA8); put(8'hB0); put(8'hAF); put(8'hB0); put(8'hA2); put(8'hB0); put(8'hA5); put(8'hB0);
    put(8'h05); put(8'hB0);
    put(8'hFF); put(8'h00); put(8'h04); put(8'h77);
    rA = '0; rT = '0; rEp = '0; rIx = '0; rSp = '0; rPc = '0; rFl = '0;
    for (int i = 0; i < 8; i++) rRi[i] = '0;

    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(accOut == 0 && tmpOut == 0 && epOut == 0 && ixOut == 0 && spOut == 0, "R1", "regs at reset",
        {accOut, tmpOut}, 0);
    chk(pcOut == 0 && flagsOut == 0 && memAddr == 0 && memRd && !memWr, "R1", "pc/fetch at reset",
        {pcOut, memAddr}, 0);
    rstN = 1'b1;

    while (int'(rPc) < progEnd) begin
      model(n, ill, tag);
      for (int k = 0; k < n; k++) begin
        chk(done == (k == n - 1), "R10", "done timing", done, k == n - 1);
        chk(illegal == (ill && k == 0), "R11", "illegal flag", illegal, ill);
        if (k < n - 1) @(negedge clk);
      end
      @(negedge clk);
      chk(accOut == rA, tag, "accumulator", accOut, rA);
      chk(tmpOut == rT, tag, "temporary", tmpOut, rT);
      chk(epOut == rEp && ixOut == rIx && spOut == rSp, tag, "pointer/index/stack",
          {epOut, ixOut}, {rEp, rIx});
      chk(flagsOut == rFl, "R5", "flags", flagsOut, rFl);
      chk(pcOut == rPc, tag, "program counter", pcOut, rPc);
    end

    mism = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== refMem[i]) mism++;
    chk(mism == 0, "R4", "memory image mismatches", mism, 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule